// File: doc/BRIEF.md
# Multicycle Writeback Hazard Controller

This block is the decode-stage interlock for an in-order pipeline whose two functional units finish after different numbers of cycles. By default these are a one-cycle ALU and a four-cycle multiplier. Every cycle, decode presents one candidate instruction: two source register indices, a destination index, a unit selector and a valid flag. The controller answers in the same cycle with a stall whenever that instruction cannot safely issue.

An instruction cannot issue in three cases:
- one of its sources is still awaiting a result (read-after-write);
- its destination already has a write in flight (write-after-write);
- the single register-file write port is already claimed for the cycle in which this instruction would finish.

Write-after-read needs no check, because issue is in order.

The controller keeps a countdown per register. It also keeps a shifting reservation table in which each entry stands for one future cycle of the write port. The entry for the current cycle drives the writeback selection outputs, which name the register and the unit that own the port in that cycle. Register 0 is never a hazard and is never written.

Top module: `hz_wb_ctl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `stall` and `wb_valid` are low and no register is pending.
- R2: An instruction is stalled while either nonzero source names a register whose result is still outstanding. A result from an instruction accepted in cycle c with latency L is outstanding in cycles c+1 through c+L. The source is readable from cycle c+L+1.
- R3: An instruction with a nonzero destination is stalled while that destination has an outstanding write, by the same window as R2.
- R4: An instruction with a nonzero destination and latency L, presented in cycle t, is stalled if another accepted instruction already writes back in cycle t+L.
- R5: Register index 0 in any source or destination position never causes a stall.
- R6: An accepted instruction with nonzero destination d and latency L, accepted in cycle c, drives `wb_valid`=1 and `wb_reg`=d in cycle c+L. `wb_valid` is 0 in every cycle that no write was reserved for.
- R7: `stall` is combinational in the cycle of the presented instruction and is 0 whenever `issue_valid` is 0.
- R8: An accepted instruction whose destination is 0 reserves no write-port slot and produces no writeback.
- R9: `unit_sel`=0 selects the ALU with latency `ALU_LAT` (default 1). `unit_sel`=1 selects the multiplier with latency `MUL_LAT` (default 4). `wb_unit` reports the selector of the instruction that owns the port.
- R10: A stalled instruction leaves no trace: it reserves no slot and marks no register pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Decode holds a candidate instruction |
| unit_sel | input | 1 | 0 = ALU, 1 = multiplier |
| src_a | input | $clog2(NUM_REGS) | First source register index |
| src_b | input | $clog2(NUM_REGS) | Second source register index |
| dst | input | $clog2(NUM_REGS) | Destination register index, 0 = no write |
| stall | output | 1 | Hold the candidate in decode this cycle |
| wb_valid | output | 1 | The write port is used this cycle |
| wb_reg | output | $clog2(NUM_REGS) | Register written this cycle |
| wb_unit | output | 1 | Unit that owns the write port this cycle |

## Verification
A writeback from an earlier multiplier instruction can land in the very cycle in which decode asks for a slot or reads the register being written. The stall decision and the writeback selection therefore depend on the same reservation within one cycle. The bench provokes this in two ways. It follows a multiplier with an ALU instruction placed so that both would finish together. It also follows it with a consumer that retries every cycle up to and past the producer's writeback. A behavioural model keeps absolute due-cycles per register and per writeback. Against that model the bench judges both the stall and the writeback outputs in every cycle, under directed sequences and a long run of random instructions confined to a few registers.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic {
    UNIT_ALU = 1'b0,
    UNIT_MUL = 1'b1
  } unit_e;

  // Latency of the selected unit, never below one cycle.
  function automatic int unsigned unit_latency(unit_e u, int unsigned alu_lat,
                                               int unsigned mul_lat);
    int unsigned l;
    l = (u == UNIT_MUL) ? mul_lat : alu_lat;
    return (l == 0) ? 1 : l;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hz_resv_table.sv
// Write-port reservation table: slot k holds the writer due k cycles ahead.
module hz_resv_table #(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned RW    = 5,
  parameter int unsigned LW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_en,
  input  logic [LW-1:0] ins_lat,
  input  logic [RW-1:0] ins_reg,
  input  logic          ins_unit,
  input  logic [LW-1:0] probe_lat,
  output logic          probe_busy,
  output logic          wb_valid,
  output logic [RW-1:0] wb_reg,
  output logic          wb_unit
);

  logic [DEPTH-1:0] busy_w;
  logic [RW-1:0]    reg_w  [DEPTH];
  logic             unit_w [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic          b_q;
    logic [RW-1:0] r_q;
    logic          u_q;
    logic          load;

    // A writer with latency L lands in slot L-1 after this edge.
    assign load = ins_en && (ins_lat == LW'(i + 1));

    if (i == DEPTH - 1) begin : g_top
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          b_q <= 1'b0;
          r_q <= '0;
          u_q <= 1'b0;
        end else if (load) begin
          b_q <= 1'b1;
          r_q <= ins_reg;
          u_q <= ins_unit;
        end else begin
          b_q <= 1'b0;
          r_q <= '0;
          u_q <= 1'b0;
        end
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          b_q <= 1'b0;
          r_q <= '0;
          u_q <= 1'b0;
        end else if (load) begin
          b_q <= 1'b1;
          r_q <= ins_reg;
          u_q <= ins_unit;
        end else begin
          b_q <= busy_w[i+1];
          r_q <= reg_w[i+1];
          u_q <= unit_w[i+1];
        end
      end
    end

    assign busy_w[i] = b_q;
    assign reg_w[i]  = r_q;
    assign unit_w[i] = u_q;
  end

  always_comb begin
    probe_busy = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (probe_lat == LW'(i)) probe_busy = busy_w[i];
    end
  end

  assign wb_valid = busy_w[0];
  assign wb_reg   = reg_w[0];
  assign wb_unit  = unit_w[0];

endmodule

// File: rtl/hz_pend_file.sv
// Per-register countdown of cycles until the outstanding write commits.
module hz_pend_file #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned RW       = 5,
  parameter int unsigned LW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [RW-1:0] set_reg,
  input  logic [LW-1:0] set_val,
  input  logic [RW-1:0] q_a,
  input  logic [RW-1:0] q_b,
  input  logic [RW-1:0] q_d,
  output logic          busy_a,
  output logic          busy_b,
  output logic          busy_d
);

  logic [LW-1:0] cnt_w [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    if (r == 0) begin : g_zero
      assign cnt_w[r] = '0;
    end else begin : g_cnt
      logic [LW-1:0] c_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                              c_q <= '0;
        else if (set_en && set_reg == RW'(r))    c_q <= set_val;
        else if (c_q != '0)                      c_q <= c_q - 1'b1;
      end
      assign cnt_w[r] = c_q;
    end
  end

  function automatic logic pending(input logic [RW-1:0] idx);
    logic hit;
    hit = 1'b0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (idx == RW'(r)) hit = (cnt_w[r] != '0);
    end
    return hit;
  endfunction

  assign busy_a = pending(q_a);
  assign busy_b = pending(q_b);
  assign busy_d = pending(q_d);

endmodule

// File: rtl/hz_issue_gate.sv
// Combines the hazard indications into the decode stall and the accept strobes.
module hz_issue_gate (
  input  logic issue_valid,
  input  logic src_a_nz,
  input  logic src_b_nz,
  input  logic dst_nz,
  input  logic busy_a,
  input  logic busy_b,
  input  logic busy_d,
  input  logic slot_taken,
  output logic raw_hit,
  output logic waw_hit,
  output logic port_hit,
  output logic stall,
  output logic accept,
  output logic record
);

  assign raw_hit  = (src_a_nz && busy_a) || (src_b_nz && busy_b);
  assign waw_hit  = dst_nz && busy_d;
  assign port_hit = dst_nz && slot_taken;
  assign stall    = issue_valid && (raw_hit || waw_hit || port_hit);
  assign accept   = issue_valid && !stall;
  assign record   = accept && dst_nz;

endmodule

// File: rtl/hz_wb_ctl.sv
module hz_wb_ctl #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned ALU_LAT  = 1,
  parameter int unsigned MUL_LAT  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        issue_valid,
  input  logic                        unit_sel,
  input  logic [$clog2(NUM_REGS)-1:0] src_a,
  input  logic [$clog2(NUM_REGS)-1:0] src_b,
  input  logic [$clog2(NUM_REGS)-1:0] dst,
  output logic                        stall,
  output logic                        wb_valid,
  output logic [$clog2(NUM_REGS)-1:0] wb_reg,
  output logic                        wb_unit
);
  import hz_pkg::*;

  localparam int unsigned RW      = $clog2(NUM_REGS);
  localparam int unsigned MAX_LAT = max_u(unit_latency(UNIT_ALU, ALU_LAT, MUL_LAT),
                                          unit_latency(UNIT_MUL, ALU_LAT, MUL_LAT));
  localparam int unsigned DEPTH   = MAX_LAT + 1;
  localparam int unsigned LW      = $clog2(DEPTH + 1);

  // Named internal events, observed by the bound checker.
  logic          raw_hit, waw_hit, port_hit, accept, record;
  logic          busy_a, busy_b, busy_d, slot_taken;
  logic [LW-1:0] lat_sel;

  assign lat_sel = LW'(unit_latency(unit_e'(unit_sel), ALU_LAT, MUL_LAT));

  hz_pend_file #(.NUM_REGS(NUM_REGS), .RW(RW), .LW(LW)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (record),
    .set_reg (dst),
    .set_val (lat_sel),
    .q_a     (src_a),
    .q_b     (src_b),
    .q_d     (dst),
    .busy_a  (busy_a),
    .busy_b  (busy_b),
    .busy_d  (busy_d)
  );

  hz_resv_table #(.DEPTH(DEPTH), .RW(RW), .LW(LW)) u_resv (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_en     (record),
    .ins_lat    (lat_sel),
    .ins_reg    (dst),
    .ins_unit   (unit_sel),
    .probe_lat  (lat_sel),
    .probe_busy (slot_taken),
    .wb_valid   (wb_valid),
    .wb_reg     (wb_reg),
    .wb_unit    (wb_unit)
  );

  hz_issue_gate u_gate (
    .issue_valid (issue_valid),
    .src_a_nz    (src_a != '0),
    .src_b_nz    (src_b != '0),
    .dst_nz      (dst != '0),
    .busy_a      (busy_a),
    .busy_b      (busy_b),
    .busy_d      (busy_d),
    .slot_taken  (slot_taken),
    .raw_hit     (raw_hit),
    .waw_hit     (waw_hit),
    .port_hit    (port_hit),
    .stall       (stall),
    .accept      (accept),
    .record      (record)
  );

endmodule

// File: rtl/hz_wb_ctl_chk.sv
module hz_wb_ctl_chk #(
  parameter int unsigned RW      = 5,
  parameter int unsigned ALU_LAT = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          issue_valid,
  input logic          unit_sel,
  input logic [RW-1:0] src_a,
  input logic [RW-1:0] src_b,
  input logic [RW-1:0] dst,
  input logic          stall,
  input logic          wb_valid,
  input logic [RW-1:0] wb_reg,
  input logic          wb_unit,
  input logic          accept
);

  // R7
  idle_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> !stall);

  // R5
  zero_regs_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && src_a == '0 && src_b == '0 && dst == '0) |-> !stall);

  // R6
  wb_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_reg != '0));

  // R6
  alu_wb_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ALU_LAT == 1 && accept && dst != '0 && !unit_sel)
      |=> (wb_valid && wb_reg == $past(dst) && !wb_unit));

  // R3
  waw_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dst != '0) |=> (!(issue_valid && dst == $past(dst)) || stall));

  // R2
  raw_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dst != '0) |=> (!(issue_valid && src_a == $past(dst)) || stall));

endmodule

bind hz_wb_ctl hz_wb_ctl_chk #(.RW(RW), .ALU_LAT(ALU_LAT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_valid (issue_valid),
  .unit_sel    (unit_sel),
  .src_a       (src_a),
  .src_b       (src_b),
  .dst         (dst),
  .stall       (stall),
  .wb_valid    (wb_valid),
  .wb_reg      (wb_reg),
  .wb_unit     (wb_unit),
  .accept      (accept)
);

// File: tb/tb_hz_wb_ctl.sv
`timescale 1ns/100ps
module tb_hz_wb_ctl;
  localparam int NR = 32;
  localparam int RW = 5;
  localparam int LA = 1;
  localparam int LM = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          iv = 1'b0;
  logic          us = 1'b0;
  logic [RW-1:0] sa = '0, sb = '0, sd = '0;
  logic          stall, wbv, wbu;
  logic [RW-1:0] wbr;

  always #2.5 clk = ~clk;

  hz_wb_ctl #(.NUM_REGS(NR), .ALU_LAT(LA), .MUL_LAT(LM)) dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(iv), .unit_sel(us),
    .src_a(sa), .src_b(sb), .dst(sd),
    .stall(stall), .wb_valid(wbv), .wb_reg(wbr), .wb_unit(wbu)
  );

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  bit done   = 0;
  int pend_until [NR];
  int wb_reg_at [int];
  int wb_unit_at [int];
  logic obs_stall, obs_wbv;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // One decode cycle: drive, compare against the model, then advance the model.
  task automatic step(input bit v, input bit u, input int a, input int b, input int d,
                      output bit acc);
    int lat;
    bit raw, waw, port, exp_stall, exp_wb;
    string tag;
    @(negedge clk);
    iv = v; us = u; sa = RW'(a); sb = RW'(b); sd = RW'(d);
    #1;
    lat       = u ? LM : LA;                                  // R9
    raw       = v && ((a != 0 && cyc <= pend_until[a]) || (b != 0 && cyc <= pend_until[b]));
    waw       = v && d != 0 && cyc <= pend_until[d];
    port      = v && d != 0 && wb_reg_at.exists(cyc + lat);
    exp_stall = raw || waw || port;
    if (!v)        tag = "R7";
    else if (raw)  tag = "R2";
    else if (waw)  tag = "R3";
    else if (port) tag = "R4";
    else           tag = "R5";
    check(stall === exp_stall, tag, "stall", int'(stall), int'(exp_stall));
    exp_wb = wb_reg_at.exists(cyc);
    check(wbv === exp_wb, "R6", "wb_valid", int'(wbv), int'(exp_wb));
    if (exp_wb) begin
      check(int'(wbr) == wb_reg_at[cyc], "R6", "wb_reg", int'(wbr), wb_reg_at[cyc]);
      check(int'(wbu) == wb_unit_at[cyc], "R9", "wb_unit", int'(wbu), wb_unit_at[cyc]);
    end
    obs_stall = stall;
    obs_wbv   = wbv;
    acc = v && !exp_stall;
    @(posedge clk);
    if (acc && d != 0) begin                                  // R8, R10
      pend_until[d]          = cyc + lat;
      wb_reg_at[cyc + lat]   = d;
      wb_unit_at[cyc + lat]  = int'(u);
    end
    cyc++;
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, acc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit acc;
    int n;
    for (int r = 0; r < NR; r++) pend_until[r] = -1;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(stall === 1'b0, "R1", "stall in reset", int'(stall), 0);
    check(wbv === 1'b0, "R1", "wb_valid in reset", int'(wbv), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 0, 7, 8, 9, acc);
    check(obs_stall === 1'b0, "R1", "no pending after reset", int'(obs_stall), 0);
    idle(3);

    // R2 / R9: consumer of a multiplier result waits MUL_LAT cycles
    step(1, 1, 0, 0, 1, acc);
    n = 0;
    step(1, 0, 0, 1, 2, acc);
    while (!acc && n < 20) begin n++; step(1, 0, 0, 1, 2, acc); end
    check(n == LM, "R2", "raw stall cycles", n, LM);
    idle(6);

    // R4: ALU would finish together with an earlier multiplier
    step(1, 1, 0, 0, 3, acc);
    idle(2);
    n = 0;
    step(1, 0, 0, 0, 4, acc);
    while (!acc && n < 20) begin n++; step(1, 0, 0, 0, 4, acc); end
    check(n == 1, "R4", "port stall cycles", n, 1);
    idle(6);

    // R3: second write to the same register waits for the first
    step(1, 1, 0, 0, 5, acc);
    n = 0;
    step(1, 0, 0, 0, 5, acc);
    while (!acc && n < 20) begin n++; step(1, 0, 0, 0, 5, acc); end
    check(n == LM, "R3", "waw stall cycles", n, LM);
    idle(6);

    // R10: a stalled instruction marks nothing pending
    step(1, 1, 0, 0, 6, acc);
    step(1, 0, 6, 0, 7, acc);
    check(obs_stall === 1'b1, "R10", "dependent stalled", int'(obs_stall), 1);
    idle(1);
    step(1, 0, 7, 0, 0, acc);
    check(obs_stall === 1'b0, "R10", "stalled dst not pending", int'(obs_stall), 0);
    idle(6);

    // R5 / R8: register 0 is free and never written
    step(1, 1, 0, 0, 0, acc);
    step(1, 0, 0, 0, 0, acc);
    check(obs_stall === 1'b0, "R5", "reg0 no hazard", int'(obs_stall), 0);
    idle(2);
    step(0, 0, 0, 0, 0, acc);
    check(obs_wbv === 1'b0, "R8", "no writeback for reg0", int'(obs_wbv), 0);
    idle(6);

    // Random traffic on a few registers to force every hazard and coincidence
    for (int i = 0; i < 3000; i++) begin
      bit v, u;
      int a, b, d;
      v = ($urandom % 4) != 0;
      u = $urandom % 2;
      a = $urandom % 4;
      b = $urandom % 4;
      d = $urandom % 5;
      step(v, u, a, b, d, acc);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule